// File: doc/BRIEF.md
# Byte Stream Packetizer with Flush Marker and Record Gap

This block turns a byte-at-a-time producer stream into framed payload packets for a datagram transmit path. A producer hands over one byte per handshake, together with a one-bit flush marker. That is the same shape as a serial transmit port, so an existing producer state machine only needs to drive the extra marker bit. Each accepted byte is stored as a 9-bit FIFO entry: the marker in the top bit and the data in the low eight bits.

The FIFO drains into an AXI4-Stream style output (`tdata`, `tvalid`, `tready`, `tlast`). A packet closes on `tlast` in one of two cases: it has reached `MAX_LEN` bytes, or the byte being sent carries the flush marker, whichever comes first. A flush marks the end of a record. After a record ends, the output stays idle for `GAP_CYCLES` cycles, so a slow consumer downstream is not flooded with back-to-back records. Setting `GAP_CYCLES` to 0 disables this gap.

Top module: `byte_packetizer`

## Requirements
- R1: `in_ready` is low exactly when the FIFO holds `DEPTH` entries. While it is low, a byte offered with `in_valid` is not taken.
- R2: Bytes leave on `out_tdata` in the order they were accepted, with their values unchanged.
- R3: Without a flush, `out_tlast` is asserted on the `MAX_LEN`-th byte of each packet and on no earlier byte.
- R4: A byte accepted with `in_flush`=1 leaves with `out_tlast`=1 and closes its packet early. The next byte starts a new packet.
- R5: When the flush byte is also the `MAX_LEN`-th byte of its packet, exactly one `tlast` is produced. The byte after it is counted as byte 1 of a new packet.
- R6: After a byte with the flush marker is transferred, `out_tvalid` stays low for exactly `GAP_CYCLES` cycles. If data is waiting and `out_tready` is high, the next byte is transferred in the cycle after that.
- R7: A packet closed only by the length limit starts no gap: with data waiting, the next byte follows in the next cycle.
- R8: While `out_tvalid` is high and `out_tready` is low, `out_tvalid`, `out_tdata` and `out_tlast` hold their values.
- R9: After reset, `out_tvalid` is low, `in_ready` is high and the packet byte count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Producer byte |
| in_flush | input | 1 | Marks the byte as the end of a record |
| in_valid | input | 1 | Producer offers a byte |
| in_ready | output | 1 | FIFO has room for a byte |
| out_tdata | output | 8 | Payload byte |
| out_tvalid | output | 1 | Payload byte valid |
| out_tready | input | 1 | Consumer accepts the byte |
| out_tlast | output | 1 | Last byte of the packet |

## Verification
Two conditions can close a packet on the same byte: the length limit and the flush marker. The bench provokes this by pre-filling the FIFO while `out_tready` is held low. It places a flush on exactly the `MAX_LEN`-th byte and follows it with a short flushed record. It then requires exactly two `tlast` beats at the expected positions, and requires the gap to separate the two records. A second overlap, between a pending gap and backpressure, is covered by toggling `out_tready` every cycle while a record end passes through.

// File: rtl/byte_packetizer.sv
module byte_packetizer #(
  parameter int DEPTH      = 16,
  parameter int MAX_LEN    = 256,
  parameter int GAP_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_flush,
  input  logic       in_valid,
  output logic       in_ready,
  output logic [7:0] out_tdata,
  output logic       out_tvalid,
  input  logic       out_tready,
  output logic       out_tlast
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LV = $clog2(DEPTH + 1);
  localparam int CW = $clog2(MAX_LEN) + 1;
  localparam int GW = $clog2(GAP_CYCLES + 1) + 1;

  logic [8:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LV-1:0] level;
  logic [CW-1:0] beat_cnt;
  logic [GW-1:0] gap_cnt;
  logic [8:0]    head;
  logic          push, pop, head_flush, at_limit;

  assign in_ready   = (level != LV'(DEPTH));
  assign push       = in_valid && in_ready;
  assign head       = mem[rd_ptr];
  assign head_flush = head[8];
  assign out_tdata  = head[7:0];
  assign at_limit   = (beat_cnt == CW'(MAX_LEN - 1));
  assign out_tlast  = head_flush || at_limit;
  assign out_tvalid = (level != '0) && (gap_cnt == '0);
  assign pop        = out_tvalid && out_tready;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {in_flush, in_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (push && !pop)      level <= level + 1'b1;
      else if (pop && !push) level <= level - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_cnt <= '0;
      gap_cnt  <= '0;
    end else begin
      if (pop) beat_cnt <= out_tlast ? '0 : beat_cnt + 1'b1;
      if (pop && head_flush && GAP_CYCLES > 0) gap_cnt <= GW'(GAP_CYCLES);
      else if (gap_cnt != '0)                  gap_cnt <= gap_cnt - 1'b1;
    end
  end

  logic [CW-1:0] seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                    seen_q <= '0;
    else if (out_tvalid && out_tready) seen_q <= out_tlast ? '0 : seen_q + 1'b1;
  end

  // R8
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_tvalid && !out_tready |=> out_tvalid && $stable(out_tdata) && $stable(out_tlast));

  // R1
  full_persists_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready && !(out_tvalid && out_tready) |=> !in_ready);

  // R3
  length_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_tvalid && seen_q == CW'(MAX_LEN - 1) |-> out_tlast);

  // R6
  gap_after_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop && head_flush && (GAP_CYCLES > 0) |=> !out_tvalid);
endmodule

// File: tb/byte_packetizer_test.sv
module byte_packetizer_test;
  localparam int DEPTH = 16;
  localparam int MAXL  = 6;
  localparam int GAP   = 10;

  logic clk = 0, rst_n = 0;
  logic [7:0] in_data = 0;
  logic in_flush = 0, in_valid = 0, in_ready;
  logic [7:0] out_tdata;
  logic out_tvalid, out_tready = 0, out_tlast;

  byte_packetizer #(.DEPTH(DEPTH), .MAX_LEN(MAXL), .GAP_CYCLES(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_flush(in_flush),
    .in_valid(in_valid), .in_ready(in_ready), .out_tdata(out_tdata),
    .out_tvalid(out_tvalid), .out_tready(out_tready), .out_tlast(out_tlast));

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  int cyc = 0, nb = 0, rmode = 2, stab_err = 0;
  logic [7:0] bd [0:255];
  logic       bl [0:255];
  int         bc [0:255];
  logic pv = 0, pr = 0, pl = 0;
  logic [7:0] pd = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    out_tready = (rmode == 0) ? 1'b1 : (rmode == 1) ? cyc[0] : 1'b0;
    if (rst_n) begin
      if (pv && !pr && !(out_tvalid && out_tdata == pd && out_tlast == pl))
        stab_err = stab_err + 1;
      if (out_tvalid && out_tready) begin
        bd[nb] = out_tdata; bl[nb] = out_tlast; bc[nb] = cyc; nb = nb + 1;
      end
    end
    pv = out_tvalid; pr = out_tready; pd = out_tdata; pl = out_tlast;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input bit f);
    @(negedge clk);
    in_data = d; in_flush = f; in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic stop_in();
    @(negedge clk);
    in_valid = 0; in_flush = 0;
  endtask

  task automatic drain();
    rmode = 0;
    repeat (3 * GAP + 40) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_tvalid == 0, "R9 tvalid after reset", out_tvalid, 0);
    chk(in_ready == 1, "R9 in_ready after reset", in_ready, 1);
  endtask

  task automatic t_length();
    int base = nb;
    rmode = 2;
    for (int i = 0; i < 14; i++) push(8'h10 + 8'(i), i == 13);
    stop_in();
    drain();
    chk(nb - base == 14, "R2 beat count", nb - base, 14);
    for (int i = 0; i < 14; i++) begin
      chk(bd[base+i] == 8'h10 + 8'(i), "R2 data order", bd[base+i], 8'h10 + i);
      chk(bl[base+i] == (i == 5 || i == 11 || i == 13), "R3 tlast position", bl[base+i],
          (i == 5 || i == 11 || i == 13));
    end
    chk(bc[base+6] - bc[base+5] == 1, "R7 no gap after length close",
        bc[base+6] - bc[base+5], 1);
  endtask

  task automatic t_flush();
    int base = nb;
    rmode = 2;
    push(8'hA0, 0); push(8'hA1, 0); push(8'hA2, 1); push(8'hA3, 0); push(8'hA4, 1);
    stop_in();
    drain();
    chk(nb - base == 5, "R4 beat count", nb - base, 5);
    chk(bl[base+2] == 1, "R4 tlast on flush byte", bl[base+2], 1);
    chk(bl[base+0] == 0 && bl[base+1] == 0 && bl[base+3] == 0, "R4 no stray tlast",
        bl[base+3], 0);
    chk(bl[base+4] == 1, "R4 second record tlast", bl[base+4], 1);
    chk(bd[base+3] == 8'hA3, "R2 data after gap", bd[base+3], 8'hA3);
    chk(bc[base+3] - bc[base+2] == GAP + 1, "R6 gap length", bc[base+3] - bc[base+2], GAP + 1);
  endtask

  task automatic t_coincide();
    int base = nb;
    int nl = 0;
    rmode = 2;
    for (int i = 0; i < 8; i++) push(8'h50 + 8'(i), i == 5 || i == 7);
    stop_in();
    drain();
    for (int i = 0; i < nb - base; i++) nl += int'(bl[base+i]);
    chk(nb - base == 8, "R5 beat count", nb - base, 8);
    chk(nl == 2, "R5 single tlast on coincident close", nl, 2);
    chk(bl[base+5] == 1 && bl[base+7] == 1, "R5 tlast positions", bl[base+7], 1);
    chk(bc[base+6] - bc[base+5] == GAP + 1, "R6 gap after coincident close",
        bc[base+6] - bc[base+5], GAP + 1);
  endtask

  task automatic t_backpressure();
    int base = nb;
    stab_err = 0;
    rmode = 1;
    for (int i = 0; i < 9; i++) push(8'hC0 + 8'(i), i == 8);
    stop_in();
    repeat (80) @(negedge clk);
    chk(nb - base == 9, "R8 beat count under stall", nb - base, 9);
    for (int i = 0; i < 9; i++)
      chk(bd[base+i] == 8'hC0 + 8'(i), "R2 data under stall", bd[base+i], 8'hC0 + i);
    chk(bl[base+5] == 1 && bl[base+8] == 1, "R3 tlast under stall", bl[base+5], 1);
    chk(stab_err == 0, "R8 outputs held while stalled", stab_err, 0);
    drain();
  endtask

  task automatic t_full();
    int base = nb;
    rmode = 2;
    for (int i = 0; i < DEPTH; i++) push(8'h80 + 8'(i), i == DEPTH - 1);
    stop_in();
    chk(in_ready == 0, "R1 in_ready low when full", in_ready, 0);
    in_data = 8'hEE; in_flush = 1; in_valid = 1;
    repeat (3) @(negedge clk);
    chk(in_ready == 0, "R1 stays full", in_ready, 0);
    in_valid = 0; in_flush = 0;
    drain();
    chk(nb - base == DEPTH, "R1 extra byte refused", nb - base, DEPTH);
    chk(bd[nb-1] == 8'h80 + 8'(DEPTH - 1), "R1 last byte is not refused one",
        bd[nb-1], 8'h80 + DEPTH - 1);
    chk(in_ready == 1, "R1 in_ready after drain", in_ready, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_length();
    t_flush();
    t_coincide();
    t_backpressure();
    t_full();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule